// File: doc/BRIEF.md
# Shared IDE/SCSI Address Steering Decoder

This block sits on a host byte bus in front of two responders: an IDE register file and the register port of a SCSI protocol controller. Each host request is decoded into a register index. A few control registers in a secondary window are served by the block itself. A runtime mode bit decides whether requests to the primary window go to the SCSI controller or fall through to the IDE path. The block also gates the IDE interrupt on its way to the host.

The host side is a valid/ready channel. A request is held stable with `h_valid` high until `h_ready` is seen high on a rising clock edge; that edge is the accepted beat. `h_ready` and `h_rdata` come from whichever responder the request is routed to, and the block itself is always ready. Each downstream channel sees `valid` only when the request is routed to it, and its `ready` back-pressures the host directly. Internal state (mode, latched byte, interrupt mask) changes only on an accepted beat, or when the bridge enable is low.

Software switches the mode with two selector reads. Either read also masks the IDE interrupt from then on, until the bridge is disabled or reset.

Top module: `dualbus_steer`

## Requirements
- R1: The index is (h_addr with bits 13 and 5 cleared) shifted right by 2. An index of at least SEC_OFF (1024) is in the secondary window, and the secondary index is the index with bit 10 cleared. Secondary indices of 6 and above are routed to IDE.
- R2: Secondary index 0 is routed to SCSI with scsi_reg = 8 (the pseudo-DMA data port), for reads and writes alike. scsi_write, scsi_wdata and scsi_rdata are passed through.
- R3: An accepted write to secondary index 3 stores h_wdata. A read of index 3 returns the stored byte while ide_irq_in is 1, and 0x00 otherwise.
- R4: An accepted read of secondary index 4 sets SCSI mode. An accepted read of index 5 clears it. Writes to indices 4 and 5, and any access to indices 1 and 2, are claimed by the block, change nothing and read 0x00.
- R5: Either selector read (index 4 or 5) forces ide_irq_out to 0 from the next cycle on. Before that, ide_irq_out follows ide_irq_in.
- R6: In the primary window with SCSI mode set, a request is routed to SCSI with scsi_reg = index[2:0]. With SCSI mode clear, it is routed to IDE.
- R7: Requests to h_addr IRQ_ADDR (0x3020) and IRQ_ADDR+1 are always routed to IDE.
- R8: While bridge_en is 0, every request is routed to IDE, and SCSI mode and the interrupt mask are cleared.
- R9: route is one-hot every cycle (bit 0 = block-internal, bit 1 = SCSI, bit 2 = IDE). h_ready and h_rdata come from the routed responder, and at most one of scsi_valid and ide_valid is high.
- R10: Synchronous reset clears SCSI mode, the interrupt mask and the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bridge_en | input | 1 | Enables steering; low forces IDE routing and clears mode and mask |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 16 | Host byte address (low 16 bits) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Read data from the routed responder |
| route | output | 3 | One-hot route: bit 0 internal, bit 1 SCSI, bit 2 IDE |
| scsi_valid | output | 1 | Request to SCSI controller |
| scsi_ready | input | 1 | SCSI controller accepts |
| scsi_write | output | 1 | Write flag to SCSI controller |
| scsi_reg | output | 4 | SCSI register index (8 = pseudo-DMA port) |
| scsi_wdata | output | 8 | Write data to SCSI controller |
| scsi_rdata | input | 8 | Read data from SCSI controller |
| ide_valid | output | 1 | Request to IDE path |
| ide_ready | input | 1 | IDE path accepts |
| ide_write | output | 1 | Write flag to IDE path |
| ide_addr | output | 16 | Unmodified host address to IDE path |
| ide_wdata | output | 8 | Write data to IDE path |
| ide_rdata | input | 8 | Read data from IDE path |
| ide_irq_in | input | 1 | Interrupt pending from IDE drive |
| ide_irq_out | output | 1 | Gated IDE interrupt to host |

## Verification
The assertions assume the host holds a request stable while it waits for ready, and that reset is applied before the first beat. The bench changes the request only after a rising edge at which the beat was accepted, or on purpose during a stall to show that a stalled beat changes nothing. The assertions also assume bridge_en changes only between beats. The stimulus toggles it only while h_valid is low, or on a request it expects to go to IDE.

// File: rtl/dualbus_steer_pkg.sv
package dualbus_steer_pkg;
  typedef enum logic [2:0] {
    RT_SELF = 3'b001,
    RT_SCSI = 3'b010,
    RT_IDE  = 3'b100
  } route_e;

  localparam int SIDX_W = 3;
endpackage

// File: rtl/dualbus_steer_dec.sv
module dualbus_steer_dec
  import dualbus_steer_pkg::*;
#(
  parameter int          AW          = 16,
  parameter int          REG_W       = 4,
  parameter int          SEC_OFF     = 1024,
  parameter int          SEC_IDE_MIN = 6,
  parameter int          PDMA_REG    = 8,
  parameter logic [15:0] HOLE_MASK   = 16'h2020,
  parameter logic [15:0] IRQ_ADDR    = 16'h3020
) (
  input  logic [AW-1:0]     addr,
  input  logic              enable,
  input  logic              scsi_mode,
  output route_e            route,
  output logic [REG_W-1:0]  scsi_reg,
  output logic [SIDX_W-1:0] sidx
);
  localparam int IDXW = AW - 2;

  logic [AW-1:0]   masked;
  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] sec_idx;
  logic            in_sec;
  logic            irq_hit;

  assign masked  = addr & ~AW'(HOLE_MASK);
  assign idx     = masked[AW-1:2];
  assign in_sec  = idx >= IDXW'(SEC_OFF);
  assign sec_idx = idx & ~IDXW'(SEC_OFF);
  assign irq_hit = (addr & ~AW'(1)) == AW'(IRQ_ADDR);
  assign sidx    = sec_idx[SIDX_W-1:0];

  always_comb begin
    route    = RT_IDE;
    scsi_reg = '0;
    if (enable && !irq_hit) begin
      if (in_sec) begin
        if (sec_idx < IDXW'(SEC_IDE_MIN)) begin
          if (sec_idx == '0) begin
            route    = RT_SCSI;
            scsi_reg = REG_W'(PDMA_REG);
          end else begin
            route = RT_SELF;
          end
        end
      end else if (scsi_mode) begin
        route    = RT_SCSI;
        scsi_reg = REG_W'(idx[2:0]);
      end
    end
  end
endmodule

// File: rtl/dualbus_steer_ctrl.sv
module dualbus_steer_ctrl
  import dualbus_steer_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LATCH_IX = 3,
  parameter int SEL_SCSI = 4,
  parameter int SEL_IDE  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              acc,
  input  logic              write,
  input  logic [SIDX_W-1:0] sidx,
  input  logic [DW-1:0]     wdata,
  input  logic              ide_irq_in,
  output logic              scsi_mode,
  output logic [DW-1:0]     rdata,
  output logic              ide_irq_out
);
  logic          mask_q;
  logic [DW-1:0] latch_q;
  logic          sel_rd;

  assign sel_rd = acc && !write &&
                  (sidx == SIDX_W'(SEL_SCSI) || sidx == SIDX_W'(SEL_IDE));

  always_ff @(posedge clk) begin
    if (rst) begin
      scsi_mode <= 1'b0;
      mask_q    <= 1'b0;
      latch_q   <= '0;
    end else if (!enable) begin
      scsi_mode <= 1'b0;
      mask_q    <= 1'b0;
    end else begin
      if (sel_rd) begin
        mask_q    <= 1'b1;
        scsi_mode <= (sidx == SIDX_W'(SEL_SCSI));
      end
      if (acc && write && sidx == SIDX_W'(LATCH_IX))
        latch_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (sidx == SIDX_W'(LATCH_IX) && ide_irq_in)
      rdata = latch_q;
  end

  assign ide_irq_out = ide_irq_in && !mask_q;

  // R5: a selector read masks the interrupt from the next cycle
  a_r5_sel_masks_irq: assert property (@(posedge clk) disable iff (rst)
    (enable && sel_rd) |=> !ide_irq_out);
  // R8: disable clears the mode
  a_r8_disable_clears_mode: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !scsi_mode);
  // R3: a latch write stores the data
  a_r3_latch_store: assert property (@(posedge clk) disable iff (rst)
    (enable && acc && write && sidx == SIDX_W'(LATCH_IX)) |=> latch_q == $past(wdata));
endmodule

// File: rtl/dualbus_steer.sv
module dualbus_steer
  import dualbus_steer_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bridge_en,
  input  logic             h_valid,
  output logic             h_ready,
  input  logic             h_write,
  input  logic [AW-1:0]    h_addr,
  input  logic [DW-1:0]    h_wdata,
  output logic [DW-1:0]    h_rdata,
  output logic [2:0]       route,
  output logic             scsi_valid,
  input  logic             scsi_ready,
  output logic             scsi_write,
  output logic [REG_W-1:0] scsi_reg,
  output logic [DW-1:0]    scsi_wdata,
  input  logic [DW-1:0]    scsi_rdata,
  output logic             ide_valid,
  input  logic             ide_ready,
  output logic             ide_write,
  output logic [AW-1:0]    ide_addr,
  output logic [DW-1:0]    ide_wdata,
  input  logic [DW-1:0]    ide_rdata,
  input  logic             ide_irq_in,
  output logic             ide_irq_out
);
  route_e            rt;
  logic              mode;
  logic [SIDX_W-1:0] sidx;
  logic [DW-1:0]     self_rdata;
  logic              acc_self;

  dualbus_steer_dec #(.AW(AW), .REG_W(REG_W)) u_dec (
    .addr(h_addr), .enable(bridge_en), .scsi_mode(mode),
    .route(rt), .scsi_reg(scsi_reg), .sidx(sidx)
  );

  assign acc_self = h_valid && (rt == RT_SELF);

  dualbus_steer_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .enable(bridge_en), .acc(acc_self),
    .write(h_write), .sidx(sidx), .wdata(h_wdata),
    .ide_irq_in(ide_irq_in), .scsi_mode(mode),
    .rdata(self_rdata), .ide_irq_out(ide_irq_out)
  );

  assign route      = rt;
  assign scsi_valid = h_valid && (rt == RT_SCSI);
  assign ide_valid  = h_valid && (rt == RT_IDE);
  assign scsi_write = h_write;
  assign scsi_wdata = h_wdata;
  assign ide_write  = h_write;
  assign ide_wdata  = h_wdata;
  assign ide_addr   = h_addr;

  always_comb begin
    unique case (rt)
      RT_SCSI: begin h_ready = scsi_ready; h_rdata = scsi_rdata; end
      RT_IDE:  begin h_ready = ide_ready;  h_rdata = ide_rdata;  end
      default: begin h_ready = 1'b1;       h_rdata = self_rdata; end
    endcase
  end

  // R9: exactly one route each cycle
  a_r9_route_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(route));
  // R9: never both downstream channels at once
  a_r9_single_valid: assert property (@(posedge clk) disable iff (rst)
    !(scsi_valid && ide_valid));
  // R8: disabled bridge steers everything to IDE
  a_r8_off_to_ide: assert property (@(posedge clk) disable iff (rst)
    !bridge_en |-> route == 3'b100);
  // R7: interrupt-status bytes never leave the IDE path
  a_r7_irq_addr_ide: assert property (@(posedge clk) disable iff (rst)
    ((h_addr & 16'hFFFE) == 16'h3020) |-> !scsi_valid);
endmodule

// File: tb/sim_dualbus_steer.sv
module sim_dualbus_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bridge_en = 1'b1;
  logic        h_valid = 1'b0, h_write = 1'b0;
  logic [15:0] h_addr = '0;
  logic [7:0]  h_wdata = '0;
  logic        h_ready;
  logic [7:0]  h_rdata;
  logic [2:0]  route;
  logic        scsi_valid, scsi_write, ide_valid, ide_write, ide_irq_out;
  logic        scsi_ready = 1'b1, ide_ready = 1'b1, ide_irq_in = 1'b0;
  logic [3:0]  scsi_reg;
  logic [7:0]  scsi_wdata, ide_wdata;
  logic [7:0]  scsi_rdata = 8'hA5, ide_rdata = 8'h3C;
  logic [15:0] ide_addr;

  int vectors = 0, miscompares = 0;
  bit m_mode = 0, m_mask = 0;
  int m_latch = 0;

  always #10 clk = ~clk;

  dualbus_steer u0 (.*);

  task automatic chk(string tag, string what, int got, int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // Reference: returns 1 internal, 2 SCSI, 4 IDE; sets register and secondary index
  function automatic int ref_route(int a, output int sreg, output int six);
    int idx;
    idx = (a & 'hDFDF) / 4;
    sreg = 0; six = idx % 1024 + (idx / 2048) * 1024;
    if (!bridge_en || a == 'h3020 || a == 'h3021) return 4;
    if (idx >= 1024) begin
      if (six >= 6) return 4;
      if (six == 0) begin sreg = 8; return 2; end
      return 1;
    end
    if (m_mode) begin sreg = idx % 8; return 2; end
    return 4;
  endfunction

  task automatic step(string tag, bit v, bit w, int a, int d);
    int er, sreg, six, erd, erdy;
    h_valid = v; h_write = w; h_addr = 16'(a); h_wdata = 8'(d);
    #5;
    er = ref_route(a, sreg, six);
    erdy = (er == 2) ? scsi_ready : (er == 4) ? ide_ready : 1;
    erd  = (er == 2) ? scsi_rdata : (er == 4) ? ide_rdata :
           ((six == 3 && ide_irq_in) ? m_latch : 0);
    chk(tag, "route", route, er);
    chk(tag, "h_ready", h_ready, erdy);
    chk(tag, "h_rdata", h_rdata, erd);
    chk(tag, "scsi_valid", scsi_valid, v && er == 2);
    chk(tag, "ide_valid", ide_valid, v && er == 4);
    chk(tag, "ide_irq_out", ide_irq_out, ide_irq_in && !m_mask);
    if (er == 2) begin
      chk(tag, "scsi_reg", scsi_reg, sreg);
      chk(tag, "scsi_wdata", scsi_wdata, d & 255);
    end
    if (er == 4) chk(tag, "ide_addr", ide_addr, a);
    @(posedge clk);
    if (!bridge_en) begin m_mode = 0; m_mask = 0; end
    else if (v && er == 1) begin
      if (w && six == 3) m_latch = d & 255;
      if (!w && (six == 4 || six == 5)) begin m_mask = 1; m_mode = (six == 4); end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state: mode clear, mask clear, stored byte zero
    ide_irq_in = 1;
    step("R10", 1, 0, 'h0004, 0);
    step("R10", 1, 0, 'h100C, 0);
    // R6: primary window in IDE mode
    step("R6", 1, 1, 'h0008, 'h11);
    // R3: store and read back under interrupt
    step("R3", 1, 1, 'h100C, 'h5A);
    ide_irq_in = 0;
    step("R3", 1, 0, 'h100C, 0);
    ide_irq_in = 1;
    step("R3", 1, 0, 'h100C, 0);
    // R7: interrupt-status bytes go to IDE (0x3020 would otherwise be index 0)
    step("R7", 1, 0, 'h3020, 0);
    step("R7", 1, 1, 'h3021, 'h77);
    // R2: pseudo-DMA port read and write, with stall
    step("R2", 1, 0, 'h1000, 0);
    step("R2", 1, 1, 'h1000, 'hC3);
    scsi_ready = 0;
    step("R2", 1, 1, 'h1000, 'h44);
    scsi_ready = 1;
    // R1: secondary index 6 and above go to IDE; hole bits alias
    step("R1", 1, 0, 'h1018, 0);
    step("R1", 1, 0, 'h101C, 0);
    step("R1", 1, 0, 'h4000, 0);
    // R4: writes to selectors and access to 1,2 change nothing
    step("R4", 1, 1, 'h1010, 'hFF);
    step("R4", 1, 0, 'h1004, 0);
    step("R4", 1, 1, 'h1008, 'h01);
    step("R4", 1, 0, 'h0008, 0);
    step("R5", 0, 0, 'h0008, 0);
    // R4/R5: selector read to SCSI mode masks irq
    step("R4", 1, 0, 'h1010, 0);
    step("R5", 1, 0, 'h0008, 0);
    // R6: SCSI mode primary access, aliasing via hole bits, high index
    step("R6", 1, 1, 'h2028, 'h99);
    step("R6", 1, 0, 'h0044, 0);
    ide_ready = 0; scsi_ready = 0;
    step("R9", 1, 0, 'h0004, 0);
    step("R9", 1, 0, 'h3020, 0);
    ide_ready = 1; scsi_ready = 1;
    step("R9", 0, 0, 'h1014, 0);
    step("R6", 1, 0, 'h0004, 0);
    // R4: select IDE mode
    step("R4", 1, 0, 'h1014, 0);
    step("R5", 1, 0, 'h0004, 0);
    step("R4", 1, 0, 'h1010, 0);
    // R8: disable clears mode and mask
    bridge_en = 0;
    step("R8", 0, 0, 'h1000, 0);
    step("R8", 1, 0, 'h1000, 0);
    step("R8", 1, 0, 'h1010, 0);
    bridge_en = 1;
    step("R8", 1, 0, 'h0004, 0);
    step("R8", 1, 0, 'h100C, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule